// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps the time of day and the calendar date as eight packed-BCD registers: hundredths of a second, seconds, minutes, hours, day of week, date, month and year. A single-cycle tick enable at 100 Hz advances the count. Each register passes its carry to the next one when it wraps. A byte-wide port can load any register or read it back. A serial access controller uses this port to transfer the time in or out one register at a time.

The hours register has a mode bit that selects a 12-hour or a 24-hour encoding, and in 12-hour mode an AM/PM flag. The day-of-week register also holds two control bits: an oscillator-stop bit that freezes all counting, and a reset-enable bit that is stored for the access controller. The last date of each month depends on the month and the year, and February gets its 29th day in leap years.

Top module: `bcd_calendar`

## Requirements
- R1: After reset, the registers read: address 0 = 0x00, 1 = 0x00, 2 = 0x00, 3 = 0x00, 4 = 0x31, 5 = 0x01, 6 = 0x01, 7 = 0x00.
- R2: While the clock is running, each tick increments hundredths from 00 to 99. Hundredths wrap to 00 and carry into seconds. Seconds and minutes each count 00 to 59 and carry into the next register.
- R3: Bit 5 of the day register (address 4) stops the oscillator when it is 1. While it is 1, ticks change no register. This bit resets to 1.
- R4: Hours is at address 3. When its bit 7 is 0, hours use 24-hour mode, with bits 5:0 holding BCD 00 to 23. In this mode 23 wraps to 00 and advances the day.
- R5: When hours bit 7 is 1, the block uses 12-hour mode. Bit 5 is the PM flag (1 = PM), and bits 4:0 count 12, 01, ..., 11. The flag toggles when the hour steps from 11 to 12. The day advances when the hour steps from 11 PM to 12 AM. Bit 7 never changes except by a write.
- R6: The day of week is held in bits 2:0 of address 4. It counts 01 to 07 and wraps to 01 when the day advances. Bits 5 and 4 are kept when it wraps. Bit 4 is the reset-enable bit and resets to 1.
- R7: The date (address 5) wraps to 01 and advances the month after 30 for months 04, 06, 09 and 11, and after 31 for all other months except February.
- R8: February ends on 29 when the BCD year (address 7) is divisible by 4, including 00, and on 28 otherwise.
- R9: The month (address 6) wraps from 12 to 01 and advances the year. The year wraps from 99 to 00.
- R10: Unused bits always read 0, whatever value was written to them. The unused bits are: bit 7 of addresses 1 and 2, bit 6 of address 3, bits 7, 6 and 3 of address 4, bits 7 and 6 of address 5, and bits 7 to 5 of address 6.
- R11: A write in the same cycle as a tick takes priority. The addressed register takes the written value and no register counts in that cycle.
- R12: rd_data shows the register selected by addr in the same cycle, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | 100 Hz count enable, one cycle wide |
| wr_en | input | 1 | Write strobe for the register at addr |
| addr | input | 3 | Register select, 0 = hundredths through 7 = year |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 8 | Selected register, combinational |

## Verification
The main test loads the registers with a time of 99 hundredths, 59 seconds and 59 minutes. Each row then sets a different hour, date, month and year and applies one tick. The rows separate the cases of a plain hour step, a 12-hour AM/PM toggle with and without a day change, and 12 to 01. They also cover 30- and 31-day month ends, February in a leap year, a common year and 2000, and the year-end wrap. Further directed tests check three things. Ticks while the oscillator is stopped leave the registers unchanged. A write that collides with a tick takes priority. Writing all ones shows which bits are discarded.

// File: rtl/bcd_calendar.sv
module bcd_calendar (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data
);
  logic [7:0] r_hund, r_sec, r_min, r_hr, r_day, r_date, r_mon, r_yr;
  logic [7:0] hr_nx, dow_nx, last_date;
  logic [7:0] h24_inc, h12_inc;
  logic [1:0] yr_mod4;
  logic       run, c_sec, c_min, c_hr, hr_wrap, c_day, c_mon, c_yr;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    bcd_inc = (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  assign run   = tick & ~r_day[5];
  assign c_sec = r_hund == 8'h99;
  assign c_min = c_sec && r_sec == 8'h59;
  assign c_hr  = c_min && r_min == 8'h59;

  assign h24_inc = bcd_inc({2'b00, r_hr[5:0]});
  assign h12_inc = bcd_inc({3'b000, r_hr[4:0]});

  always_comb begin
    if (!r_hr[7]) begin
      hr_wrap = r_hr[5:0] == 6'h23;
      hr_nx   = hr_wrap ? 8'h00 : {2'b00, h24_inc[5:0]};
    end else if (r_hr[4:0] == 5'h11) begin
      hr_wrap = r_hr[5];
      hr_nx   = {2'b10, ~r_hr[5], 5'h12};
    end else if (r_hr[4:0] == 5'h12) begin
      hr_wrap = 1'b0;
      hr_nx   = {2'b10, r_hr[5], 5'h01};
    end else begin
      hr_wrap = 1'b0;
      hr_nx   = {2'b10, r_hr[5], h12_inc[4:0]};
    end
  end

  assign c_day  = c_hr && hr_wrap;
  assign dow_nx = (r_day[2:0] == 3'd7) ? {r_day[7:3], 3'd1} : r_day + 8'd1;

  assign yr_mod4 = {r_yr[4], 1'b0} + r_yr[1:0];

  always_comb begin
    case (r_mon)
      8'h02:                      last_date = (yr_mod4 == 2'd0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_date = 8'h30;
      default:                    last_date = 8'h31;
    endcase
  end

  assign c_mon = c_day && r_date == last_date;
  assign c_yr  = c_mon && r_mon == 8'h12;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_hund <= 8'h00; r_sec  <= 8'h00; r_min <= 8'h00; r_hr <= 8'h00;
      r_day  <= 8'h31; r_date <= 8'h01; r_mon <= 8'h01; r_yr <= 8'h00;
    end else if (wr_en) begin
      case (addr)
        3'd0: r_hund <= wr_data;
        3'd1: r_sec  <= wr_data & 8'h7F;
        3'd2: r_min  <= wr_data & 8'h7F;
        3'd3: r_hr   <= wr_data & 8'hBF;
        3'd4: r_day  <= wr_data & 8'h37;
        3'd5: r_date <= wr_data & 8'h3F;
        3'd6: r_mon  <= wr_data & 8'h1F;
        default: r_yr <= wr_data;
      endcase
    end else if (run) begin
      r_hund <= c_sec ? 8'h00 : bcd_inc(r_hund);
      if (c_sec) r_sec  <= c_min ? 8'h00 : bcd_inc(r_sec);
      if (c_min) r_min  <= c_hr ? 8'h00 : bcd_inc(r_min);
      if (c_hr)  r_hr   <= hr_nx;
      if (c_day) r_day  <= dow_nx;
      if (c_day) r_date <= c_mon ? 8'h01 : bcd_inc(r_date);
      if (c_mon) r_mon  <= c_yr ? 8'h01 : bcd_inc(r_mon);
      if (c_yr)  r_yr   <= (r_yr == 8'h99) ? 8'h00 : bcd_inc(r_yr);
    end
  end

  always_comb begin
    case (addr)
      3'd0: rd_data = r_hund;
      3'd1: rd_data = r_sec;
      3'd2: rd_data = r_min;
      3'd3: rd_data = r_hr;
      3'd4: rd_data = r_day;
      3'd5: rd_data = r_date;
      3'd6: rd_data = r_mon;
      default: rd_data = r_yr;
    endcase
  end
endmodule

module bcd_calendar_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       wr_en,
  input logic [2:0] addr,
  input logic [7:0] wr_data,
  input logic [7:0] hund,
  input logic [7:0] sec,
  input logic [7:0] hr,
  input logic [7:0] day,
  input logic [7:0] date,
  input logic [7:0] mon
);
  assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0) |=> hund == $past(wr_data));

  assert_halt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && day[5]) |=> $stable(hund) && $stable(sec));

  assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !tick) |=> $stable(hund) && $stable(sec));

  assert_mode_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(hr[7]));

  assert_zero_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sec[7] == 1'b0 && hr[6] == 1'b0 && day[7:6] == 2'b00 && day[3] == 1'b0 &&
    date[7:6] == 2'b00 && mon[7:5] == 3'b000);
endmodule

bind bcd_calendar bcd_calendar_chk chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
  .wr_data(wr_data), .hund(r_hund), .sec(r_sec), .hr(r_hr), .day(r_day),
  .date(r_date), .mon(r_mon)
);

// File: tb/bcd_calendar_test.sv
module bcd_calendar_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bcd_calendar uut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
                    .addr(addr), .wr_data(wr_data), .rd_data(rd_data));

  // hr_in, dow_in, date_in, mon_in, yr_in, hr_ex, dow_ex, date_ex, mon_ex, yr_ex
  localparam logic [79:0] VEC [14] = '{
    80'h23_07_31_12_99_00_01_01_01_00,
    80'h23_03_28_02_23_00_04_01_03_23,
    80'h23_03_28_02_24_00_04_29_02_24,
    80'h23_05_29_02_24_00_06_01_03_24,
    80'h23_01_30_04_25_00_02_01_05_25,
    80'h23_01_30_01_25_00_02_31_01_25,
    80'h19_02_15_06_25_20_02_15_06_25,
    80'h91_02_15_06_25_B2_02_15_06_25,
    80'hB1_02_15_06_25_92_03_16_06_25,
    80'h92_02_15_06_25_81_02_15_06_25,
    80'h23_06_28_02_00_00_07_29_02_00,
    80'h23_04_30_11_10_00_05_01_12_10,
    80'h23_07_30_09_10_00_01_01_10_10,
    80'h23_17_10_06_25_00_11_11_06_25
  };

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr = a;
    #1;
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s addr %0d actual %h expected %h", tag, a, rd_data, exp);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values, read through the port (R12)
    chk(0, 8'h00, "R1/R12"); chk(1, 8'h00, "R1"); chk(2, 8'h00, "R1");
    chk(3, 8'h00, "R1"); chk(4, 8'h31, "R1 R6"); chk(5, 8'h01, "R1");
    chk(6, 8'h01, "R1"); chk(7, 8'h00, "R1");

    // R3 oscillator stopped after reset
    repeat (3) pulse_tick();
    chk(0, 8'h00, "R3 stopped after reset");
    wr(4, 8'h01);
    pulse_tick();
    chk(0, 8'h01, "R3 running");
    wr(4, 8'h21);
    pulse_tick();
    chk(0, 8'h01, "R3 stopped by bit");

    // R2 carries
    wr(4, 8'h01);
    wr(0, 8'h09);
    pulse_tick();
    chk(0, 8'h10, "R2 BCD digit carry");
    wr(0, 8'h99); wr(1, 8'h59); wr(2, 8'h12);
    pulse_tick();
    chk(0, 8'h00, "R2"); chk(1, 8'h00, "R2"); chk(2, 8'h13, "R2");

    // R11 write collides with tick
    wr(0, 8'h99); wr(1, 8'h10);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'd0; wr_data = 8'h42; tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    chk(0, 8'h42, "R11 written value");
    chk(1, 8'h10, "R11 no count");

    // R10 discarded bits
    wr(1, 8'hFF); chk(1, 8'h7F, "R10");
    wr(2, 8'hFF); chk(2, 8'h7F, "R10");
    wr(3, 8'hFF); chk(3, 8'hBF, "R10");
    wr(4, 8'hFF); chk(4, 8'h37, "R10");
    wr(5, 8'hFF); chk(5, 8'h3F, "R10");
    wr(6, 8'hFF); chk(6, 8'h1F, "R10");

    // rollover table: R4 R5 R6 R7 R8 R9
    for (int i = 0; i < 14; i++) begin
      logic [79:0] v;
      v = VEC[i];
      wr(4, 8'h21);
      wr(0, 8'h99); wr(1, 8'h59); wr(2, 8'h59);
      wr(3, v[79:72]); wr(5, v[63:56]); wr(6, v[55:48]); wr(7, v[47:40]);
      wr(4, v[71:64]);
      pulse_tick();
      chk(0, 8'h00, "R2 row");
      chk(1, 8'h00, "R2 row");
      chk(2, 8'h00, "R2 row");
      chk(3, v[39:32], "R4/R5 hours");
      chk(4, v[31:24], "R6 day of week");
      chk(5, v[23:16], "R7/R8 date");
      chk(6, v[15:8],  "R9 month");
      chk(7, v[7:0],   "R9 year");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule